// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of a successive-approximation analog-to-digital converter. It runs a binary search against an external comparator. Each trial code goes out on `dac_code`, and the comparator answers on `cmp_in`. The search runs from the most significant bit down to the least significant bit, one decision per conversion-clock cycle. The search comes after a sampling window, and the window length is chosen so that every conversion lasts exactly the cycle count fixed by its resolution and its sample-and-hold setting.

Configuration arrives as register-style levels:

- resolution: 8 or 10 bits
- mode: one-shot or repeat
- input channel: one of four
- sample-and-hold: on or off
- trigger source: software or a timer event

Software sets a start bit with a pulse on `start_set` and clears it with a pulse on `start_clr`. The finished code is held in `result`, and `done` pulses once per conversion. While the reference-connect enable is low, the block does not convert, so the resistor ladder can be left unpowered.

Top module: `sar_seq`

## Requirements
- R1: After synchronous reset the block is in this state: `result` = 0, `done` = 0, `busy` = 0, `start_bit` = 0 and `sampling` = 0.
- R2: With `res_hi`=1 in one-shot mode, `result` is the largest 10-bit code that does not exceed the analog input. The comparator convention is `cmp_in`=1 when the input is at or above `dac_code`.
- R3: With `res_hi`=0, only bits 9..2 of `dac_code` are trialled and bits 1..0 stay 0. `result` carries the 8-bit code in bits 7..0, and bits 9..8 read 0.
- R4: A conversion keeps `busy` high for exactly N clock cycles. N is 49 for 8-bit without sample-and-hold, 59 for 10-bit without it, 28 for 8-bit with `sh_en`=1, and 33 for 10-bit with it. `result` and `done` update on the edge that ends the last cycle.
- R5: `sampling` is high for the first N-1-B cycles of a conversion, where B is the resolution in bits. The B bit decisions follow, MSB first. The final cycle only latches the result.
- R6: With `trig_timer`=0, a conversion begins on the first clock edge at which the block is idle and `start_bit` is 1. This is the edge after the `start_set` pulse.
- R7: With `trig_timer`=1, a conversion begins only on an edge where `timer_evt`=1, `start_bit`=1 and the block is idle. A timer event while `start_bit` is 0 starts nothing.
- R8: With `rpt_mode`=1, `res_hi` is ignored and every conversion is 8-bit. While `start_bit` stays 1, a new conversion begins after one idle cycle. A `start_clr` pulse lets the running conversion finish and then nothing further starts.
- R9: In one-shot mode `start_bit` returns to 0 on the completion edge. `done` is high for exactly one cycle per conversion. `start_set` wins over `start_clr` when both are high.
- R10: While `ref_en`=0, no conversion starts and `start_bit` keeps its value. Dropping `ref_en` during a conversion abandons it: `done` does not pulse and `result` keeps its value. `ref_conn` follows `ref_en`.
- R11: During a conversion, `ain_sel` equals 8 + `chan_sel`, with `chan_sel` captured when the conversion begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Synchronous active-low reset |
| res_hi | input | 1 | 1 selects 10-bit, 0 selects 8-bit |
| rpt_mode | input | 1 | 1 selects repeat mode, 0 selects one-shot |
| chan_sel | input | 2 | Analog channel choice |
| sh_en | input | 1 | Sample-and-hold enable |
| trig_timer | input | 1 | 1 selects the timer trigger, 0 the software trigger |
| ref_en | input | 1 | Reference-connect enable |
| start_set | input | 1 | Pulse that sets the start bit |
| start_clr | input | 1 | Pulse that clears the start bit |
| timer_evt | input | 1 | Timer interrupt request |
| cmp_in | input | 1 | Comparator result, 1 when input >= dac_code |
| dac_code | output | 10 | Trial code, left-aligned in 8-bit mode |
| ain_sel | output | 4 | Selected channel number, 8 to 11 |
| ref_conn | output | 1 | Drive to the reference ladder switch |
| sampling | output | 1 | High during the sampling window |
| busy | output | 1 | Conversion in progress |
| start_bit | output | 1 | Current start bit |
| done | output | 1 | One-cycle completion pulse |
| result | output | 10 | Last completed conversion code |

## Verification
The bench drives inputs and samples outputs at the falling edge. For a software start, `done` and the new `result` must appear after exactly N+2 rising edges from the edge that sees `start_set`: one edge latches the start bit, one launches the conversion, and N more complete it. The bench checks that `done` is still low one cycle earlier. For a timer start the count is N+1 edges from the edge that sees `timer_evt`. In repeat mode, consecutive `done` pulses must be N+1 cycles apart. Over each conversion the bench counts the falling-edge samples with `sampling` high and compares that count with N-1-B.

// File: rtl/sar_seq_pkg.sv
// Shared constants and helpers for the conversion sequencer.
// Assumes the longest conversion fits in CNT_W bits.
package sar_seq_pkg;
    localparam int RES_W      = 10;   // full code width
    localparam int LO_W       = 8;    // reduced code width
    localparam int CYC_LO_DIR = 49;   // 8-bit, no sample-and-hold
    localparam int CYC_HI_DIR = 59;   // 10-bit, no sample-and-hold
    localparam int CYC_LO_SH  = 28;   // 8-bit, sample-and-hold
    localparam int CYC_HI_SH  = 33;   // 10-bit, sample-and-hold
    localparam int CNT_W      = $clog2(CYC_HI_DIR + 1);
    localparam int POS_W      = $clog2(RES_W);
    localparam int CH_W       = 2;
    localparam int AIN_W      = 4;
    localparam int AIN_BASE   = 8;

    // Total conversion length in clocks for a resolution/hold pair.
    function automatic logic [CNT_W-1:0] conv_cycles(input logic hi, input logic sh);
        if (sh) return hi ? CNT_W'(CYC_HI_SH)  : CNT_W'(CYC_LO_SH);
        else    return hi ? CNT_W'(CYC_HI_DIR) : CNT_W'(CYC_LO_DIR);
    endfunction

    // Number of bit decisions for a resolution.
    function automatic logic [CNT_W-1:0] step_count(input logic hi);
        return hi ? CNT_W'(RES_W) : CNT_W'(LO_W);
    endfunction
endpackage

// File: rtl/sar_ctrl.sv
// Start-bit register and conversion state machine.
// Assumes conv_last comes from the timing unit and is high only while busy.
module sar_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic start_set,
    input  logic start_clr,
    input  logic trig_timer,
    input  logic timer_evt,
    input  logic ref_en,
    input  logic rpt_mode,
    input  logic conv_last,
    output logic start_bit,
    output logic busy,
    output logic launch,
    output logic finish,
    output logic done,
    output logic rpt_q
);
    // Begin when idle, armed, reference connected and the trigger is met.
    always_comb launch = !busy && start_bit && ref_en && (!trig_timer || timer_evt);
    // A conversion counts as complete only if the reference stayed connected.
    always_comb finish = busy && ref_en && conv_last;

    // State, start bit and the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            start_bit <= 1'b0;
            done      <= 1'b0;
            rpt_q     <= 1'b0;
        end else begin
            if (launch)
                busy <= 1'b1;
            else if (busy && (!ref_en || conv_last))
                busy <= 1'b0;
            if (launch)
                rpt_q <= rpt_mode;
            if (start_set)
                start_bit <= 1'b1;
            else if (start_clr)
                start_bit <= 1'b0;
            else if (finish && !rpt_q)
                start_bit <= 1'b0;
            done <= finish;
        end
    end

    // R10
    ref_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(ref_en));
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9
    oneshot_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !rpt_q && !$past(start_set)) |-> !start_bit);
endmodule

// File: rtl/sar_timing.sv
// Cycle counter and phase decode for one conversion.
// Captures resolution, hold mode and channel when a conversion begins.
// Order within a conversion: sampling window, then bit steps, then a latch cycle.
module sar_timing
    import sar_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic             busy,
    input  logic             res_hi,
    input  logic             rpt_mode,
    input  logic             sh_en,
    input  logic [CH_W-1:0]  chan_sel,
    output logic             conv_last,
    output logic             step_en,
    output logic [POS_W-1:0] bit_pos,
    output logic             sampling,
    output logic             hi_q,
    output logic [CH_W-1:0]  ch_q
);
    logic             sh_q;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] total;
    logic [CNT_W-1:0] first;
    logic [CNT_W-1:0] off;

    // Counter and captured configuration; repeat mode forces 8-bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            hi_q <= 1'b0;
            sh_q <= 1'b0;
            ch_q <= '0;
        end else if (launch) begin
            cnt  <= '0;
            hi_q <= res_hi && !rpt_mode;
            sh_q <= sh_en;
            ch_q <= chan_sel;
        end else if (busy) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // Phase decode from the count and the captured settings.
    always_comb begin
        total     = conv_cycles(hi_q, sh_q);
        first     = total - CNT_W'(1) - step_count(hi_q);
        off       = cnt - first;
        sampling  = busy && (cnt < first);
        step_en   = busy && (cnt >= first) && (cnt < total - CNT_W'(1));
        conv_last = busy && (cnt == total - CNT_W'(1));
        bit_pos   = POS_W'(RES_W - 1) - off[POS_W-1:0];
    end

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt < total));
    // R5
    sample_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sampling && cnt != '0) |-> $past(sampling));
endmodule

// File: rtl/sar_search.sv
// Successive-approximation register, trial code and result register.
// Codes are kept left-aligned in RES_W bits; 8-bit results are shifted down on store.
module sar_search
    import sar_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic             step_en,
    input  logic [POS_W-1:0] bit_pos,
    input  logic             cmp_in,
    input  logic             finish,
    input  logic             hi_q,
    output logic [RES_W-1:0] dac_code,
    output logic [RES_W-1:0] result
);
    logic [RES_W-1:0] acc;
    logic [RES_W-1:0] trial_bit;

    // Trial code is the decided bits plus the bit under test.
    always_comb begin
        trial_bit = RES_W'(1) << bit_pos;
        dac_code  = step_en ? (acc | trial_bit) : acc;
    end

    // Keep the bit under test when the comparator says the input is at or above the trial code.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc <= '0;
        else if (launch)
            acc <= '0;
        else if (step_en && cmp_in)
            acc <= acc | trial_bit;
    end

    // Store the finished code, right-aligned in 8-bit mode.
    always_ff @(posedge clk) begin
        if (!rst_n)
            result <= '0;
        else if (finish)
            result <= hi_q ? acc : RES_W'(acc >> (RES_W - LO_W));
    end

    // R2
    msb_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && $past(step_en)) |-> (bit_pos == POS_W'($past(bit_pos) - POS_W'(1))));
    // R3
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(finish) && !$past(hi_q)) |-> (result[RES_W-1:LO_W] == '0));
endmodule

// File: rtl/sar_seq.sv
// Top of the conversion sequencer: control, timing and search units.
// Assumes cmp_in settles within one clock of dac_code changing.
module sar_seq
    import sar_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             res_hi,
    input  logic             rpt_mode,
    input  logic [CH_W-1:0]  chan_sel,
    input  logic             sh_en,
    input  logic             trig_timer,
    input  logic             ref_en,
    input  logic             start_set,
    input  logic             start_clr,
    input  logic             timer_evt,
    input  logic             cmp_in,
    output logic [RES_W-1:0] dac_code,
    output logic [AIN_W-1:0] ain_sel,
    output logic             ref_conn,
    output logic             sampling,
    output logic             busy,
    output logic             start_bit,
    output logic             done,
    output logic [RES_W-1:0] result
);
    logic             launch;
    logic             finish;
    logic             rpt_q;
    logic             conv_last;
    logic             step_en;
    logic [POS_W-1:0] bit_pos;
    logic             hi_q;
    logic [CH_W-1:0]  ch_q;

    sar_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_set(start_set), .start_clr(start_clr),
        .trig_timer(trig_timer), .timer_evt(timer_evt), .ref_en(ref_en),
        .rpt_mode(rpt_mode), .conv_last(conv_last), .start_bit(start_bit),
        .busy(busy), .launch(launch), .finish(finish), .done(done), .rpt_q(rpt_q)
    );

    sar_timing u_timing (
        .clk(clk), .rst_n(rst_n), .launch(launch), .busy(busy), .res_hi(res_hi),
        .rpt_mode(rpt_mode), .sh_en(sh_en), .chan_sel(chan_sel),
        .conv_last(conv_last), .step_en(step_en), .bit_pos(bit_pos),
        .sampling(sampling), .hi_q(hi_q), .ch_q(ch_q)
    );

    sar_search u_search (
        .clk(clk), .rst_n(rst_n), .launch(launch), .step_en(step_en),
        .bit_pos(bit_pos), .cmp_in(cmp_in), .finish(finish), .hi_q(hi_q),
        .dac_code(dac_code), .result(result)
    );

    // Channel number and reference switch drive.
    always_comb begin
        ain_sel  = AIN_W'(AIN_BASE) + AIN_W'(ch_q);
        ref_conn = ref_en;
    end
endmodule

// File: tb/sar_seq_tb.sv
module sar_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       res_hi = 1'b0, rpt_mode = 1'b0, sh_en = 1'b0, trig_timer = 1'b0;
    logic       ref_en = 1'b1, start_set = 1'b0, start_clr = 1'b0, timer_evt = 1'b0;
    logic [1:0] chan_sel = 2'd0;
    logic [9:0] vin = 10'd0;
    logic       cmp_in;
    logic [9:0] dac_code, result;
    logic [3:0] ain_sel;
    logic       ref_conn, sampling, busy, start_bit, done;
    int         n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;   // 125 MHz
    assign cmp_in = (vin >= dac_code);

    sar_seq dut_i (
        .clk(clk), .rst_n(rst_n), .res_hi(res_hi), .rpt_mode(rpt_mode),
        .chan_sel(chan_sel), .sh_en(sh_en), .trig_timer(trig_timer), .ref_en(ref_en),
        .start_set(start_set), .start_clr(start_clr), .timer_evt(timer_evt),
        .cmp_in(cmp_in), .dac_code(dac_code), .ain_sel(ain_sel), .ref_conn(ref_conn),
        .sampling(sampling), .busy(busy), .start_bit(start_bit), .done(done),
        .result(result)
    );

    function automatic int exp_cycles(input logic hi, input logic sh);
        if (sh) return hi ? 33 : 28;
        return hi ? 59 : 49;
    endfunction

    function automatic logic [9:0] exp_code(input logic [9:0] v, input logic hi);
        return hi ? v : {2'b00, v[9:2]};
    endfunction

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Software one-shot conversion with full timing, sampling and channel checks.
    task automatic oneshot(input logic [9:0] v, input logic hi, input logic sh, input logic [1:0] ch);
        int t = exp_cycles(hi, sh);
        int nb = hi ? 10 : 8;
        int smp = 0;
        logic [3:0] seen_ch = 4'd0;
        int done_early = 0;
        @(negedge clk);
        vin = v; res_hi = hi; sh_en = sh; chan_sel = ch; rpt_mode = 0; trig_timer = 0;
        start_set = 1;
        @(negedge clk);
        start_set = 0;
        for (int i = 1; i <= t; i++) begin
            @(negedge clk);
            if (sampling) smp++;
            if (i == 1) seen_ch = ain_sel;
            if (done) done_early++;
        end
        chk(done_early == 0, "R4 no early done", done_early, 0);
        chk(smp == t - 1 - nb, "R5 sampling length", smp, t - 1 - nb);
        chk(seen_ch == 4'(8 + ch), "R11 channel", seen_ch, 8 + ch);
        @(negedge clk);
        chk(done == 1, "R4 R6 done due", done, 1);
        chk(result == exp_code(v, hi), hi ? "R2 result" : "R3 result", result, exp_code(v, hi));
        chk(start_bit == 0 && busy == 0, "R9 start bit cleared", start_bit, 0);
        @(negedge clk);
        chk(done == 0, "R9 done one cycle", done, 0);
    endtask

    task automatic quiet(input int n, input string req);
        int hits = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (done || busy) hits++;
        end
        chk(hits == 0, req, hits, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [9:0] keep;
        int t;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(result == 0 && done == 0 && busy == 0 && start_bit == 0 && sampling == 0,
            "R1 reset state", {result, done, busy, start_bit, sampling}, 0);
        chk(ref_conn == 1, "R10 ref_conn follows", ref_conn, 1);

        // Directed corners: all four timing classes and code extremes (R2 R3 R4)
        oneshot(10'd1023, 1, 0, 2'd0);
        oneshot(10'd0,    1, 1, 2'd3);
        oneshot(10'd1023, 0, 0, 2'd1);
        oneshot(10'd3,    0, 1, 2'd2);
        oneshot(10'd512,  1, 0, 2'd1);
        oneshot(10'd511,  1, 1, 2'd0);

        // Random one-shot conversions
        for (int k = 0; k < 24; k++)
            oneshot(10'($urandom), 1'($urandom), 1'($urandom), 2'($urandom));

        // R8 repeat mode: 10-bit requested but forced to 8-bit, restarts with one idle cycle
        @(negedge clk);
        vin = 10'd777; res_hi = 1; sh_en = 0; rpt_mode = 1; trig_timer = 0; start_set = 1;
        @(negedge clk);
        start_set = 0;
        repeat (49) @(negedge clk);
        @(negedge clk);
        chk(done == 1 && result == 10'd194, "R8 first repeat result", result, 194);
        for (int i = 0; i < 49; i++) begin
            @(negedge clk);
            if (i == 48) chk(done == 0, "R8 no early repeat", done, 0);
        end
        vin = 10'd100;
        @(negedge clk);
        chk(done == 1 && result == 10'd194, "R8 repeat period", done, 1);
        start_clr = 1;
        @(negedge clk);
        start_clr = 0;
        chk(start_bit == 0 && busy == 1, "R8 clear keeps running", busy, 1);
        repeat (48) @(negedge clk);
        @(negedge clk);
        chk(done == 1 && result == 10'd25, "R8 last repeat result", result, 25);
        rpt_mode = 0;
        quiet(120, "R8 stopped after clear");

        // R9 start_set beats start_clr
        @(negedge clk);
        ref_en = 0; start_set = 1; start_clr = 1;
        @(negedge clk);
        start_set = 0; start_clr = 0;
        chk(start_bit == 1, "R9 set priority", start_bit, 1);
        // R10 no start while reference disconnected
        quiet(60, "R10 no start with ref off");
        chk(start_bit == 1 && ref_conn == 0, "R10 start bit kept", start_bit, 1);
        vin = 10'd600; res_hi = 1; sh_en = 1;
        ref_en = 1;
        for (int i = 0; i < 33; i++) begin
            @(negedge clk);
            if (i == 32) chk(done == 0, "R10 no early done", done, 0);
        end
        @(negedge clk);
        chk(done == 1 && result == 10'd600, "R10 resume converts", result, 600);

        // R10 abort mid-conversion
        keep = result;
        @(negedge clk);
        vin = 10'd5; start_set = 1;
        @(negedge clk);
        start_set = 0;
        repeat (10) @(negedge clk);
        ref_en = 0;
        @(negedge clk);
        chk(busy == 0, "R10 abort stops", busy, 0);
        quiet(70, "R10 aborted no done");
        chk(result == keep && start_bit == 1, "R10 result kept", result, keep);
        ref_en = 1;
        repeat (33) @(negedge clk);
        @(negedge clk);
        chk(done == 1 && result == 10'd5, "R10 restart after abort", result, 5);

        // R7 timer trigger
        @(negedge clk);
        trig_timer = 1; res_hi = 0; sh_en = 0; vin = 10'd1000; start_set = 1;
        @(negedge clk);
        start_set = 0;
        quiet(80, "R7 wait for timer event");
        t = exp_cycles(0, 0);
        timer_evt = 1;
        @(negedge clk);
        timer_evt = 0;
        for (int i = 1; i < t; i++) begin
            @(negedge clk);
            if (i == t - 1) chk(done == 0, "R7 no early done", done, 0);
        end
        @(negedge clk);
        chk(done == 1 && result == 10'd250, "R7 timer conversion", result, 250);
        chk(start_bit == 0, "R9 timer one-shot clears", start_bit, 0);
        timer_evt = 1;
        @(negedge clk);
        timer_evt = 0;
        quiet(80, "R7 event without start bit");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule